// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter, 4 bits wide by default. It steps up or down on the rising edge of one shared clock. A parallel value can be preset through an active-low synchronous load. Counting is allowed only when two active-low enables are both asserted. A direction input selects the count direction. Every state bit changes on the same clock edge, and control inputs take effect only at that edge.

An active-low carry output flags the terminal count. The terminal count is all ones when counting up and zero when counting down. The carry is also qualified by the second enable. Because of this, stages chain into a wider synchronous counter with no extra gating:

- Each stage's carry drives the next stage's second enable.
- A common enable drives the first enable of every stage.
- Load, direction and clock are shared by all stages.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0, whatever the clock does.
- R2: When `load_n` is low at a rising edge, `q_o` equals `din_i` after that edge. The values of `cnt_en_n`, `chain_en_n` and `up_dn` have no effect in that cycle.
- R3: When `load_n` is high and either `cnt_en_n` or `chain_en_n` is high at a rising edge, `q_o` holds its value.
- R4: When `load_n` is high, both enables are low and `up_dn` is 1, `q_o` increments by one at the edge. It wraps from 15 to 0.
- R5: When `load_n` is high, both enables are low and `up_dn` is 0, `q_o` decrements by one at the edge. It wraps from 0 to 15.
- R6: `carry_n` is combinational and has no register delay. It is 0 exactly when `chain_en_n` is 0 and one of these holds:
  - `up_dn` is 1 and `q_o` is 15.
  - `up_dn` is 0 and `q_o` is 0.
- R7: `carry_n` is 1 whenever `chain_en_n` is 1, for any count and direction. The value of `cnt_en_n` does not affect `carry_n`.
- R8: Two stages can be chained into an 8-bit counter that counts correctly up and down across the nibble boundary and wraps. The low stage's `carry_n` drives the high stage's `chain_en_n`, and `cnt_en_n`, `load_n` and `up_dn` are shared.
- R9: A pulse on `load_n` (or on any control input) that starts and ends between two rising edges leaves `q_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the count |
| load_n | input | 1 | Active-low synchronous preset |
| cnt_en_n | input | 1 | Active-low count enable shared by all stages |
| chain_en_n | input | 1 | Active-low count enable that also qualifies the carry |
| up_dn | input | 1 | Count direction: 1 counts up, 0 counts down |
| din_i | input | WIDTH | Preset value |
| q_o | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count carry for the next stage |

## Verification
The count is registered once, so load, hold and step results are due one rising edge after the inputs that cause them. The carry is combinational, so it is due in the same cycle as the count and inputs it decodes. The bench drives inputs on the falling edge and samples on the next falling edge. It compares the count with a model that applies the preceding edge's inputs, and it compares the carry with the count and inputs present at that sample point. The 8-bit chain is checked every cycle across full up and down sweeps against an arithmetic modulo-256 model. This places any one-cycle carry-to-enable dependency at the expected edge.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } ctr_op_e;
endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
    import updn_ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    cnt_en_n,
    input  logic    chain_en_n,
    input  logic    up_dn,
    output ctr_op_e op
);
    always_comb begin
        if (!load_n)
            op = OP_LOAD;               // preset wins over counting
        else if (!cnt_en_n && !chain_en_n)
            op = up_dn ? OP_INC : OP_DEC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_step.sv
module ctr_step
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt_next
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: cnt_next = din;
            OP_INC:  cnt_next = cnt + ONE;
            OP_DEC:  cnt_next = cnt - ONE;
            default: cnt_next = cnt;
        endcase
    end
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             up_dn,
    input  logic             chain_en_n,
    output logic             carry_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic at_end;

    always_comb begin
        at_end  = up_dn ? (cnt == TOP) : (cnt == '0);
        carry_n = !(at_end && !chain_en_n);
    end
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
    import updn_ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             chain_en_n,
    input  logic             up_dn,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] q_o,
    output logic             carry_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } ctr_state_t;

    ctr_state_t       state_d, state_q;
    ctr_op_e          op;
    logic [WIDTH-1:0] cnt_next;

    ctr_mode_dec u_dec (
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .up_dn      (up_dn),
        .op         (op)
    );

    ctr_step #(.WIDTH(WIDTH)) u_step (
        .op       (op),
        .cnt      (state_q.cnt),
        .din      (din_i),
        .cnt_next (cnt_next)
    );

    ctr_carry #(.WIDTH(WIDTH)) u_carry (
        .cnt        (state_q.cnt),
        .up_dn      (up_dn),
        .chain_en_n (chain_en_n),
        .carry_n    (carry_n)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q_o = state_q.cnt;

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |-> q_o == '0);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q_o == $past(din_i));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_en_n || chain_en_n)) |=> $stable(q_o));

    // R4
    inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && up_dn)
        |=> q_o == WIDTH'($past(q_o) + 1'b1));

    // R5
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && !up_dn)
        |=> q_o == WIDTH'($past(q_o) - 1'b1));

    // R7
    carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en_n |-> carry_n);

    // R6
    carry_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_en_n && up_dn && q_o == TOP) |-> !carry_n);
endmodule

// File: tb/tb_updn_cascade_counter.sv
`timescale 1ns/1ps
module tb_updn_cascade_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       chain_en_n = 1'b1;
    logic       up_dn = 1'b1;
    logic [3:0] din_lo = '0;
    logic [3:0] din_hi = '0;
    logic [3:0] q_lo, q_hi;
    logic       carry_lo, carry_hi;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_q;
    logic [7:0] exp_v;

    always #2.5 clk = ~clk;

    updn_cascade_counter #(.WIDTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .chain_en_n(chain_en_n), .up_dn(up_dn), .din_i(din_lo),
        .q_o(q_lo), .carry_n(carry_lo));

    updn_cascade_counter #(.WIDTH(4)) hi (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
        .chain_en_n(carry_lo), .up_dn(up_dn), .din_i(din_hi),
        .q_o(q_hi), .carry_n(carry_hi));

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic exp_carry(input logic [3:0] q, input logic up, input logic ent);
        return !(!ent && (up ? (q == 4'hF) : (q == 4'h0)));
    endfunction

    // model update for the edge about to happen, then sample at next negedge
    task automatic tick(input string req);
        if (!load_n) exp_q = din_lo;
        else if (!cnt_en_n && !chain_en_n) exp_q = up_dn ? exp_q + 4'd1 : exp_q - 4'd1;
        @(posedge clk);
        @(negedge clk);
        chk(req, q_lo, exp_q);
        chk("R6", carry_lo, exp_carry(q_lo, up_dn, chain_en_n));
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        exp_q = '0;
        repeat (3) @(negedge clk);
        chk("R1", q_lo, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: load every value, with enables in every combination and both directions
        for (int v = 0; v < 16; v++) begin
            load_n = 1'b0; din_lo = 4'(v);
            cnt_en_n = v[0]; chain_en_n = v[1]; up_dn = v[2];
            tick("R2");
        end
        load_n = 1'b1;

        // R4: up sweep with wrap
        din_lo = 4'd0; load_n = 1'b0; tick("R2"); load_n = 1'b1;
        cnt_en_n = 1'b0; chain_en_n = 1'b0; up_dn = 1'b1;
        for (int i = 0; i < 20; i++) tick("R4");

        // R5: down sweep with wrap
        up_dn = 1'b0;
        for (int i = 0; i < 20; i++) tick("R5");

        // R3: hold with either enable high
        cnt_en_n = 1'b1; chain_en_n = 1'b0;
        for (int i = 0; i < 4; i++) tick("R3");
        cnt_en_n = 1'b0; chain_en_n = 1'b1;
        for (int i = 0; i < 4; i++) tick("R3");

        // R7: carry stays high at terminal counts when the chain enable is high
        for (int v = 0; v < 16; v++) begin
            load_n = 1'b0; din_lo = 4'(v); chain_en_n = 1'b1; cnt_en_n = v[0];
            tick("R2");
            for (int d = 0; d < 2; d++) begin
                up_dn = d[0];
                #0.1;
                chk("R7", carry_lo, 1);
            end
        end
        load_n = 1'b1;

        // R6: carry goes low at 15 up and 0 down with chain enable low
        load_n = 1'b0; din_lo = 4'hF; tick("R2"); load_n = 1'b1;
        cnt_en_n = 1'b1; chain_en_n = 1'b0; up_dn = 1'b1; #0.1;
        chk("R6", carry_lo, 0);
        up_dn = 1'b0; #0.1;
        chk("R6", carry_lo, 1);
        load_n = 1'b0; din_lo = 4'h0; tick("R2"); load_n = 1'b1; #0.1;
        chk("R6", carry_lo, 0);

        // R9: a load pulse between edges has no effect
        cnt_en_n = 1'b1; chain_en_n = 1'b1;
        load_n = 1'b0; din_lo = 4'h9; #1; load_n = 1'b1; up_dn = 1'b1;
        tick("R9");

        // R8: 8-bit chain up from 0xF8 then down
        din_lo = 4'h8; din_hi = 4'hF; load_n = 1'b0; tick("R2"); load_n = 1'b1;
        exp_v = 8'hF8;
        chk("R8", {q_hi, q_lo}, exp_v);
        cnt_en_n = 1'b0; chain_en_n = 1'b0; up_dn = 1'b1;
        for (int i = 0; i < 300; i++) begin
            exp_v = exp_v + 8'd1;
            tick("R4");
            chk("R8", {q_hi, q_lo}, exp_v);
        end
        up_dn = 1'b0;
        for (int i = 0; i < 300; i++) begin
            exp_v = exp_v - 8'd1;
            tick("R5");
            chk("R8", {q_hi, q_lo}, exp_v);
        end
        // common enable high freezes the whole chain
        cnt_en_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick("R3");
            chk("R8", {q_hi, q_lo}, exp_v);
        end

        // R1: asynchronous reset mid-run
        #1 rst_n = 1'b0; #0.5;
        chk("R1", q_lo, 0);
        chk("R1", q_hi, 0);
        @(negedge clk); rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule